// File: doc/BRIEF.md
# File-Operand Instruction Decoder

This block decodes a 12-bit accumulator-style instruction word into the data-memory access it needs. For each executed instruction it produces a registered read strobe, a registered write strobe, a file address and an operation class. The read strobe is gated by instruction class, and it is not simply derived from the presence of a 5-bit address field. Literal, control, store-only and clear instructions therefore never touch the register file. This matters for registers whose read has a side effect, such as a receive buffer that pops on read or a flag register that clears on read. An accidental read of such a register loses data.

The 5-bit file field in the low bits of the word selects one of 32 direct locations. Field value 0 means indirect access: the effective address is then the pointer value supplied on `ptr_i`. The execute strobe `exec_i` is a plain control input. The decoder accepts one instruction in every cycle in which the strobe is high and never applies back-pressure, so the block has no ready signal. Results appear one clock after the strobe is sampled. In a cycle without the strobe, both access strobes fall low, and the class and address outputs keep their last values.

Top module: `file_access_decoder`

## Requirements
- R1: The all-zero word 0x000 (no-operation) issues neither a read nor a write, even when the indirect pointer addresses a side-effect register. Its class is 0 (control).
- R2: Words 0x080 to 0x3FF (byte operations on a file) issue a read. They issue a write only when bit 5 is 1, and their class is 3. In particular, 0x200 + f (move file to working register) reads f and does not write it.
- R3: Words 0x020 to 0x03F (store working register to file) issue a write and no read. Their class is 1.
- R4: Words 0x040 to 0x05F (clear working register) issue no access. Words 0x060 to 0x07F (clear file) issue a write and no read. Both ranges have class 2.
- R5: Words 0x800 to 0xFFF (literal and branch operations) issue no access, and their class is 5.
- R6: Words 0x001 to 0x01F (control operations, including option load, sleep, watchdog clear and direction load) issue no access. Their class is 0.
- R7: Words 0x400 to 0x7FF (bit operations) issue a read and have class 4. When bits 9:8 are 00 or 01 (bit clear or bit set), they also issue a write. When bits 9:8 are 10 or 11 (bit test), they issue no write.
- R8: The address output equals `ptr_i` when instruction bits 4:0 are zero. Otherwise it equals those bits, zero-extended.
- R9: The outputs are registered and reflect the inputs sampled one clock earlier. Each cycle in which `exec_i` is high yields at most one read pulse, one cycle long. A cycle in which `exec_i` is low leaves both strobes low in the next cycle and holds the class and address outputs.
- R10: After reset, both strobes are 0, the class is 0 and the address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_i | input | 1 | Execute strobe for the instruction on `instr_i` |
| instr_i | input | 12 | Instruction word |
| ptr_i | input | ADDR_W (8) | Indirect pointer value |
| rd_en_o | output | 1 | File read strobe |
| wr_en_o | output | 1 | File write strobe |
| addr_o | output | ADDR_W (8) | Effective file address |
| class_o | output | 3 | Operation class, using the codes given in R1 to R7 |

## Verification
The read strobe and the write strobe can be active in the same cycle for a read-modify-write instruction. The same cycle can also carry an indirect address resolution that points at a side-effect register. The bench provokes this coincidence with byte operations that have bit 5 set and with bit clear/set words whose file field is 0, while the pointer addresses the modelled receive buffer. It then judges both strobes and the address against a behavioural model. The bench counts the reads of the modelled buffer and requires that no-operation, literal, store and clear words with the same pointer leave that count unchanged.

// File: rtl/file_dec_pkg.sv
package file_dec_pkg;
  localparam int INSTR_W = 12;
  localparam int FIELD_W = 5;

  typedef enum logic [2:0] {
    CLS_CTRL  = 3'd0,
    CLS_STORE = 3'd1,
    CLS_CLEAR = 3'd2,
    CLS_BYTE  = 3'd3,
    CLS_BIT   = 3'd4,
    CLS_LIT   = 3'd5
  } op_class_e;

  typedef struct packed {
    op_class_e cls;
    logic      rd;
    logic      wr;
  } dec_t;
endpackage

// File: rtl/idec_classify.sv
module idec_classify
  import file_dec_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec = '{cls: CLS_CTRL, rd: 1'b0, wr: 1'b0};
    if (instr[11]) begin
      // literal / branch: operand field is not a file address
      dec.cls = CLS_LIT;
    end else if (instr[10]) begin
      // bit ops: clear/set are read-modify-write, tests only read
      dec.cls = CLS_BIT;
      dec.rd  = 1'b1;
      dec.wr  = ~instr[9];
    end else if (instr[9:7] != 3'b000) begin
      // byte ops consume the file; destination bit selects write-back
      dec.cls = CLS_BYTE;
      dec.rd  = 1'b1;
      dec.wr  = instr[5];
    end else begin
      unique case (instr[6:5])
        2'b00: dec.cls = CLS_CTRL;
        2'b01: begin dec.cls = CLS_STORE; dec.wr = 1'b1; end
        2'b10: dec.cls = CLS_CLEAR;
        default: begin dec.cls = CLS_CLEAR; dec.wr = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/idec_ea.sv
module idec_ea
  import file_dec_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [FIELD_W-1:0] field,
  input  logic [ADDR_W-1:0]  ptr,
  output logic [ADDR_W-1:0]  ea
);
  logic [ADDR_W-1:0] direct;
  logic              is_indirect;

  generate
    if (ADDR_W > FIELD_W) begin : g_widen
      assign direct = {{(ADDR_W-FIELD_W){1'b0}}, field};
    end else begin : g_narrow
      assign direct = field[ADDR_W-1:0];
    end
  endgenerate

  assign is_indirect = (field == '0);
  assign ea = is_indirect ? ptr : direct;
endmodule

// File: rtl/idec_gate.sv
module idec_gate
  import file_dec_pkg::*;
(
  input  logic exec,
  input  dec_t dec,
  output logic rd_req,
  output logic wr_req
);
  assign rd_req = exec & dec.rd;
  assign wr_req = exec & dec.wr;
endmodule

// File: rtl/file_access_decoder.sv
module file_access_decoder
  import file_dec_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  ptr_i,
  output logic               rd_en_o,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [2:0]         class_o
);
  dec_t              dec;
  logic [ADDR_W-1:0] ea;
  logic              rd_req, wr_req;
  op_class_e         cls_q;

  idec_classify u_cls (.instr(instr_i), .dec(dec));

  idec_ea #(.ADDR_W(ADDR_W)) u_ea (
    .field(instr_i[FIELD_W-1:0]), .ptr(ptr_i), .ea(ea)
  );

  idec_gate u_gate (.exec(exec_i), .dec(dec), .rd_req(rd_req), .wr_req(wr_req));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en_o <= 1'b0;
      wr_en_o <= 1'b0;
      addr_o  <= '0;
      cls_q   <= CLS_CTRL;
    end else begin
      rd_en_o <= rd_req;
      wr_en_o <= wr_req;
      if (exec_i) begin
        addr_o <= ea;
        cls_q  <= dec.cls;
      end
    end
  end

  assign class_o = cls_q;

  assert_nop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i == '0) |=> (!rd_en_o && !wr_en_o));

  assert_movf_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i[11:5] == 7'b0010000) |=> (rd_en_o && !wr_en_o));

  assert_store_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i[11:5] == 7'b0000001) |=> (wr_en_o && !rd_en_o));

  assert_lit_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i[11]) |=> (!rd_en_o && !wr_en_o && class_o == 3'd5));

  assert_direct_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i[4:0] != 5'd0) |=> (addr_o == ADDR_W'($past(instr_i[4:0]))));

  assert_indirect_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && instr_i[4:0] == 5'd0) |=> (addr_o == $past(ptr_i)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_i) |=> (!rd_en_o && !wr_en_o && $stable(addr_o) && $stable(class_o)));
endmodule

// File: tb/file_access_decoder_tb.sv
`timescale 1ns/1ps
module file_access_decoder_tb;
  localparam int AW = 8;
  localparam int RX = 8'h0D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_i = 1'b0;
  logic [11:0] instr_i = '0;
  logic [AW-1:0] ptr_i = '0;
  logic rd_en_o, wr_en_o;
  logic [AW-1:0] addr_o;
  logic [2:0] class_o;

  int total = 0;
  int bad = 0;
  int rx_reads = 0;
  bit done = 1'b0;

  typedef struct {
    bit    rd;
    bit    wr;
    int    cls;
    int    addr;
    string tag;
  } exp_t;

  exp_t q[$];
  int m_cls = 0;
  int m_addr = 0;

  always #4 clk = ~clk;

  file_access_decoder #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .instr_i(instr_i), .ptr_i(ptr_i),
    .rd_en_o(rd_en_o), .wr_en_o(wr_en_o), .addr_o(addr_o), .class_o(class_o)
  );

  function automatic string tag_of(int ins);
    if (ins == 0) return "R1";
    if (ins < 'h020) return "R6";
    if (ins < 'h040) return "R3";
    if (ins < 'h080) return "R4";
    if (ins < 'h400) return "R2";
    if (ins < 'h800) return "R7";
    return "R5";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    exp_t e;
    e = q.pop_front();
    check(e.tag, "rd_en", int'(rd_en_o), int'(e.rd));
    check(e.tag, "wr_en", int'(wr_en_o), int'(e.wr));
    check(e.tag, "class", int'(class_o), e.cls);
    check((e.tag == "R10" || e.tag == "R9") ? e.tag : "R8", "addr", int'(addr_o), e.addr);
    if (rd_en_o && addr_o == AW'(RX)) rx_reads++;
  endtask

  task automatic step(int ins, int ptr, bit ex);
    bit rd, wr;
    int cls;
    exp_t e;
    @(negedge clk);
    compare();
    exec_i  = ex;
    instr_i = 12'(ins);
    ptr_i   = AW'(ptr);
    rd = 0; wr = 0;
    if (ins >= 'h800) cls = 5;
    else if (ins >= 'h400) begin cls = 4; rd = 1; wr = (((ins >> 8) & 3) < 2); end
    else if (ins >= 'h080) begin cls = 3; rd = 1; wr = ((ins & 'h020) != 0); end
    else if (ins >= 'h060) begin cls = 2; wr = 1; end
    else if (ins >= 'h040) cls = 2;
    else if (ins >= 'h020) begin cls = 1; wr = 1; end
    else cls = 0;
    if (ex) begin
      m_cls  = cls;
      m_addr = ((ins & 31) == 0) ? ptr : (ins & 31);
    end
    e.rd = ex && rd;
    e.wr = ex && wr;
    e.cls = m_cls;
    e.addr = m_addr;
    e.tag = ex ? tag_of(ins) : "R9";
    q.push_back(e);
  endtask

  initial begin
    exp_t r;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r.rd = 0; r.wr = 0; r.cls = 0; r.addr = 0; r.tag = "R10";
    q.push_back(r);

    // quiet instructions aimed at the side-effect register (R1 R3 R4 R5 R6)
    base = rx_reads;
    step('h000, RX, 1);
    step('h000, RX, 1);
    step('h800 | RX, RX, 1);
    step('hA00, RX, 1);
    step('h020, RX, 1);
    step('h020 | RX, 0, 1);
    step('h040, RX, 1);
    step('h060 | RX, 0, 1);
    step('h004, RX, 1);
    step('h006, RX, 1);
    step('h000, RX, 0);
    @(negedge clk); compare();
    q.push_back('{rd: 0, wr: 0, cls: m_cls, addr: m_addr, tag: "R9"});
    check("R1", "side-effect reads after quiet words", rx_reads - base, 0);

    // move-file reads the buffer once per executed word (R2 R9)
    base = rx_reads;
    step('h200 | RX, 0, 1);
    step('h200, RX, 1);
    step('h200 | RX, 0, 1);
    step('h200 | RX, 0, 0);
    step('h000, 0, 0);
    check("R2", "side-effect reads after three moves", rx_reads - base, 3);

    // read-modify-write through the pointer (R2 R7 R8)
    step('h0E0, RX, 1);
    step('h400, RX, 1);
    step('h500, RX, 1);
    step('h600, RX, 1);
    step('h7E0, 8'hF3, 1);
    step('h3FF, 8'hF3, 1);

    // full sweep with varied pointer and strobe pattern
    for (int i = 0; i < 4096; i++) begin
      step(i, (i * 37) & 255, (i % 5) != 3);
    end
    step(0, 0, 0);
    @(negedge clk);
    compare();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule